// File: doc/BRIEF.md
# Link Retrain Sequencer

This block brings a point-to-point serial link up to its second-generation speed without software involvement. After a start pulse it acts as a bus master toward the link controller. First it changes the controller's one-time capability register so that generation 2 is the highest speed offered. Then it asks the controller to retrain the link twice. After each request it waits until training has finished. Finally it reports the speed and lane width that the link reached.

The controller side is a simple register port with one access outstanding at a time. The sequencer holds a request until the controller acknowledges it. The capability and control registers are changed by read-modify-write, so the bits the sequencer does not own keep their values. Each training wait is bounded by a number of status polls. If every poll in the budget still shows training in progress, the sequencer raises an error and finishes instead of hanging.

Top module: `link_retrain_seq`

## Requirements
- R1: After reset, done, err and bus_req are low, and cur_gen and cur_width are zero.
- R2: A start pulse is accepted only while the sequencer is idle. A start pulse during a run has no effect: there is still exactly one capability write and no more than two retrain requests.
- R3: Before any retrain request, the sequencer reads the capability register (CAP_ADDR) and writes it back with bits [17:12] and [3:0] cleared, then bits [3:0] set to 2. All other bits are preserved.
- R4: A retrain request reads the 16-bit control register (CTL_ADDR) and writes it back with bit 5 set. The other bits are preserved.
- R5: After each retrain request, the sequencer polls the status register (STS_ADDR) until bit 11 (training in progress) reads 0. It writes the control register again only after that.
- R6: A run that does not time out performs exactly two retrain-and-wait cycles.
- R7: Each time a training wait completes, cur_gen takes status bits [3:0] and cur_width takes status bits [8:4]. Both outputs hold these values until the next wait completes, so the pair from the last completed wait is presented when done is high.
- R8: A wait times out after POLL_LIMIT status reads that all show bit 11 set. The sequencer then stops polling, sets err together with done, and issues no further retrain request. err is cleared when the next start is accepted.
- R9: done is high for exactly one cycle at the end of each run, after which the sequencer is idle and issues no bus request.
- R10: bus_req stays high, with bus_addr, bus_we and bus_wdata stable, until bus_ack is seen. It drops in the cycle after the acknowledge, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (used only while idle) |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | The last run ended on a poll timeout |
| cur_gen | output | 4 | Link generation from the last completed wait |
| cur_width | output | 5 | Lane width from the last completed wait |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
A wrong state or a lost pass counter shows on the bus within one access. The controller model then sees a control write that comes too early, a third retrain, or a capability write that comes after a retrain. These are counted in the same run. A wrong poll counter shows as a status read count that is not POLL_LIMIT on a timed-out wait, or as err and done appearing at the wrong time. A field decoded from the wrong bits shows on cur_gen and cur_width in the done cycle. A timeout on the second wait must still show the values from the first wait.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CAP_RD,
        S_CAP_WR,
        S_CTL_RD,
        S_CTL_WR,
        S_STS_RD,
        S_DONE
    } seq_state_t;

    localparam int          DATA_W      = 32;
    localparam int          RETRAIN_BIT = 5;
    localparam int          BUSY_BIT    = 11;
    localparam int          GEN_LSB     = 0;
    localparam int          GEN_W       = 4;
    localparam int          LW_LSB      = 4;
    localparam int          LW_W        = 5;
    localparam logic [31:0] CAP_CLR     = 32'h0003_F00F;
    localparam logic [31:0] CAP_SEL     = 32'h0000_0002;
endpackage

// File: rtl/lrs_bus_master.sv
module lrs_bus_master #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
    } mst_t;

    mst_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (m_q.req) begin
            if (bus_ack) m_d.req = 1'b0;
        end else if (cmd_valid) begin
            m_d.req   = 1'b1;
            m_d.we    = cmd_we;
            m_d.addr  = cmd_addr;
            m_d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign rsp_valid = m_q.req & bus_ack;
    assign rsp_data  = bus_rdata;
    assign bus_req   = m_q.req;
    assign bus_we    = m_q.we;
    assign bus_addr  = m_q.addr;
    assign bus_wdata = m_q.wdata;

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req);
    assert_single_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cmd_valid);
endmodule

// File: rtl/lrs_poll_timer.sv
module lrs_poll_timer #(
    parameter int POLL_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(POLL_LIMIT - 1));

    assert_inc_below_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last);
endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq
    import lrs_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CAP_ADDR   = 'h084,
    parameter logic [ADDR_W-1:0] CTL_ADDR   = 'h088,
    parameter logic [ADDR_W-1:0] STS_ADDR   = 'h08A,
    parameter int                POLL_LIMIT = 1024,
    parameter int                RETRAINS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              err,
    output logic [3:0]        cur_gen,
    output logic [4:0]        cur_width,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    localparam int PASS_W = (RETRAINS > 1) ? $clog2(RETRAINS) : 1;

    typedef struct packed {
        seq_state_t        state;
        logic              issued;
        logic [PASS_W-1:0] pass;
        logic [31:0]       hold;
        logic [GEN_W-1:0]  gen;
        logic [LW_W-1:0]   width;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic              cmd_valid, cmd_we;
    logic [ADDR_W-1:0] cmd_addr;
    logic [31:0]       cmd_wdata;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic              tmr_clr, tmr_inc, tmr_last;

    always_comb begin
        s_d       = s_q;
        cmd_we    = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        tmr_clr   = 1'b0;
        tmr_inc   = 1'b0;
        cmd_valid = !s_q.issued && (s_q.state != S_IDLE) && (s_q.state != S_DONE);
        if (cmd_valid) s_d.issued = 1'b1;

        unique case (s_q.state)
            S_IDLE: begin
                if (start) begin
                    s_d.err    = 1'b0;
                    s_d.pass   = '0;
                    s_d.issued = 1'b0;
                    s_d.state  = S_CAP_RD;
                end
            end
            S_CAP_RD: begin
                cmd_addr = CAP_ADDR;
                if (rsp_valid) begin
                    s_d.hold   = rsp_data;
                    s_d.issued = 1'b0;
                    s_d.state  = S_CAP_WR;
                end
            end
            S_CAP_WR: begin
                cmd_we    = 1'b1;
                cmd_addr  = CAP_ADDR;
                cmd_wdata = (s_q.hold & ~CAP_CLR) | CAP_SEL;
                if (rsp_valid) begin
                    s_d.issued = 1'b0;
                    s_d.state  = S_CTL_RD;
                end
            end
            S_CTL_RD: begin
                cmd_addr = CTL_ADDR;
                if (rsp_valid) begin
                    s_d.hold   = {16'h0, rsp_data[15:0]};
                    s_d.issued = 1'b0;
                    s_d.state  = S_CTL_WR;
                end
            end
            S_CTL_WR: begin
                cmd_we    = 1'b1;
                cmd_addr  = CTL_ADDR;
                cmd_wdata = s_q.hold | (32'h1 << RETRAIN_BIT);
                if (rsp_valid) begin
                    tmr_clr    = 1'b1;
                    s_d.issued = 1'b0;
                    s_d.state  = S_STS_RD;
                end
            end
            S_STS_RD: begin
                cmd_addr = STS_ADDR;
                if (rsp_valid) begin
                    s_d.issued = 1'b0;
                    if (!rsp_data[BUSY_BIT]) begin
                        s_d.gen   = rsp_data[GEN_LSB +: GEN_W];
                        s_d.width = rsp_data[LW_LSB +: LW_W];
                        if (s_q.pass == PASS_W'(RETRAINS - 1)) begin
                            s_d.state = S_DONE;
                        end else begin
                            s_d.pass  = s_q.pass + 1'b1;
                            s_d.state = S_CTL_RD;
                        end
                    end else if (tmr_last) begin
                        s_d.err   = 1'b1;
                        s_d.state = S_DONE;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            S_DONE: begin
                s_d.state = S_IDLE;
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    lrs_bus_master #(.ADDR_W(ADDR_W)) i_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_we    (cmd_we),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    lrs_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .last  (tmr_last)
    );

    assign done      = (s_q.state == S_DONE);
    assign err       = s_q.err;
    assign cur_gen   = s_q.gen;
    assign cur_width = s_q.width;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && s_q.state == S_STS_RD) |=> $stable(cur_gen) && $stable(cur_width));
endmodule

// File: tb/test_link_retrain_seq.sv
module test_link_retrain_seq;
    localparam int          CLK_PERIOD = 10;
    localparam int          LIMIT      = 8;
    localparam logic [11:0] A_CAP      = 12'h084;
    localparam logic [11:0] A_CTL      = 12'h088;
    localparam logic [11:0] A_STS      = 12'h08A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, err, bus_req, bus_we, bus_ack;
    logic [3:0]  cur_gen;
    logic [4:0]  cur_width;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_retrain_seq #(.POLL_LIMIT(LIMIT)) i_link_retrain_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
        .cur_gen(cur_gen), .cur_width(cur_width), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // link controller model configuration (written by the bench only)
    logic        cfg_reset = 1'b0;
    logic [31:0] cfg_cap = '0;
    logic [15:0] cfg_ctl = '0;
    logic [15:0] cfg_b1 = '0, cfg_b2 = '0;
    logic [3:0]  cfg_g1 = '0, cfg_g2 = '0;
    logic [4:0]  cfg_w1 = '0, cfg_w2 = '0;
    logic [1:0]  cfg_lat = '0;

    // model state
    logic [31:0] cap_r;
    logic [15:0] ctl_r, ctl_last;
    logic [15:0] busy;
    logic [3:0]  sg, pg;
    logic [4:0]  sw, pw;
    logic [1:0]  wcnt;
    int rtr_cnt, cap_wr_cnt, sts_rd_cnt, cap_order_bad, early_bad;

    always @(posedge clk) begin
        if (!rst_n || cfg_reset) begin
            bus_ack <= 1'b0; bus_rdata <= '0; wcnt <= '0;
            cap_r <= cfg_cap; ctl_r <= cfg_ctl; ctl_last <= '0; busy <= '0;
            sg <= 4'd1; sw <= 5'd1; pg <= '0; pw <= '0;
            rtr_cnt <= 0; cap_wr_cnt <= 0; sts_rd_cnt <= 0; cap_order_bad <= 0; early_bad <= 0;
        end else begin
            bus_ack <= 1'b0;
            if (busy != 0) begin
                busy <= busy - 1'b1;
                if (busy == 16'd1) begin sg <= pg; sw <= pw; end
            end
            if (bus_req && !bus_ack) begin
                if (wcnt == cfg_lat) begin
                    wcnt <= '0;
                    bus_ack <= 1'b1;
                    if (bus_we) begin
                        if (bus_addr == A_CAP) begin
                            cap_r <= bus_wdata;
                            cap_wr_cnt <= cap_wr_cnt + 1;
                            if (rtr_cnt != 0) cap_order_bad <= cap_order_bad + 1;
                        end else if (bus_addr == A_CTL) begin
                            ctl_last <= bus_wdata[15:0];
                            ctl_r <= bus_wdata[15:0] & ~16'h0020;
                            if (cap_wr_cnt == 0) cap_order_bad <= cap_order_bad + 1;
                            if (busy != 0) early_bad <= early_bad + 1;
                            if (bus_wdata[5]) begin
                                rtr_cnt <= rtr_cnt + 1;
                                if ((rtr_cnt == 0 ? cfg_b1 : cfg_b2) == 0) begin
                                    sg <= (rtr_cnt == 0) ? cfg_g1 : cfg_g2;
                                    sw <= (rtr_cnt == 0) ? cfg_w1 : cfg_w2;
                                end else begin
                                    busy <= (rtr_cnt == 0) ? cfg_b1 : cfg_b2;
                                    pg <= (rtr_cnt == 0) ? cfg_g1 : cfg_g2;
                                    pw <= (rtr_cnt == 0) ? cfg_w1 : cfg_w2;
                                end
                            end
                        end
                    end else begin
                        if (bus_addr == A_CAP) bus_rdata <= cap_r;
                        else if (bus_addr == A_CTL) bus_rdata <= {16'h0, ctl_r};
                        else if (bus_addr == A_STS) begin
                            bus_rdata <= {16'h0, 4'h0, busy != 0, 2'b00, sw, sg};
                            sts_rd_cnt <= sts_rd_cnt + 1;
                        end else bus_rdata <= 32'hDEAD_BEEF;
                    end
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end
        end
    end

    // handshake monitor (R10)
    int hs_bad = 0;
    logic prev_req = 1'b0, prev_ack = 1'b0;
    logic [11:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_req && !prev_ack && (!bus_req || bus_addr != prev_addr)) hs_bad++;
            if (prev_req && prev_ack && bus_req) hs_bad++;
        end
        prev_req = bus_req; prev_ack = bus_ack; prev_addr = bus_addr;
    end

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_model();
        @(negedge clk) cfg_reset = 1'b1;
        @(negedge clk) cfg_reset = 1'b0;
    endtask

    task automatic run_to_done(input int mid_start_at);
        int n = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && n < 5000) begin
            n++;
            if (n == mid_start_at) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        if (!done) chk("R9 done never seen", 32'd0, 32'd1);
    endtask

    typedef struct packed {
        logic [31:0] cap;
        logic [15:0] ctl;
        logic [15:0] b1;
        logic [15:0] b2;
        logic [3:0]  g1;
        logic [4:0]  w1;
        logic [3:0]  g2;
        logic [4:0]  w2;
        logic [1:0]  lat;
        logic [1:0]  rtr;
        logic        xerr;
        logic        tmo1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'hFFFF_FFFF, 16'h0000, 16'd3,    16'd5,    4'd1, 5'd4, 4'd2, 5'd4, 2'd0, 2'd2, 1'b0, 1'b0},
        '{32'h0000_0000, 16'h0041, 16'd0,    16'd1,    4'd1, 5'd2, 4'd2, 5'd2, 2'd2, 2'd2, 1'b0, 1'b0},
        '{32'h1234_5678, 16'hFFDF, 16'd12,   16'd7,    4'd1, 5'd8, 4'd2, 5'd8, 2'd1, 2'd2, 1'b0, 1'b0},
        '{32'hA5A5_A5A5, 16'h0102, 16'd4,    16'd2000, 4'd1, 5'd1, 4'd2, 5'd3, 2'd0, 2'd2, 1'b1, 1'b0},
        '{32'h5A5A_5A5A, 16'h8000, 16'd2000, 16'd3,    4'd2, 5'd4, 4'd2, 5'd4, 2'd1, 2'd1, 1'b1, 1'b1}
    };

    logic [3:0] exp_gen = '0;
    logic [4:0] exp_w = '0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 cur_gen", {28'd0, cur_gen}, 32'd0);
        chk("R1 cur_width", {27'd0, cur_width}, 32'd0);

        foreach (VECS[i]) begin
            cfg_cap = VECS[i].cap; cfg_ctl = VECS[i].ctl;
            cfg_b1 = VECS[i].b1; cfg_b2 = VECS[i].b2;
            cfg_g1 = VECS[i].g1; cfg_w1 = VECS[i].w1;
            cfg_g2 = VECS[i].g2; cfg_w2 = VECS[i].w2;
            cfg_lat = VECS[i].lat;
            load_model();
            run_to_done(0);
            if (!VECS[i].tmo1) begin
                exp_gen = VECS[i].xerr ? VECS[i].g1 : VECS[i].g2;
                exp_w   = VECS[i].xerr ? VECS[i].w1 : VECS[i].w2;
            end
            chk("R3 capability value", cap_r, (VECS[i].cap & ~32'h0003_F00F) | 32'h2);
            chk("R3 capability order", cap_order_bad, 0);
            chk("R4 control write", {16'h0, ctl_last}, {16'h0, VECS[i].ctl | 16'h0020});
            chk("R5 write during training", early_bad, 0);
            chk("R6 retrain count", rtr_cnt, {30'd0, VECS[i].rtr});
            chk("R7 cur_gen", {28'd0, cur_gen}, {28'd0, exp_gen});
            chk("R7 cur_width", {27'd0, cur_width}, {27'd0, exp_w});
            chk("R8 err", {31'd0, err}, {31'd0, VECS[i].xerr});
            if (VECS[i].tmo1) chk("R8 polls before timeout", sts_rd_cnt, LIMIT);
            @(negedge clk);
            chk("R9 done one cycle", {31'd0, done}, 32'd0);
        end

        // start during a run is ignored (R2), then idle (R9)
        cfg_cap = 32'h0F0F_0F0F; cfg_ctl = 16'h0004; cfg_b1 = 16'd10; cfg_b2 = 16'd10;
        cfg_g1 = 4'd1; cfg_w1 = 5'd2; cfg_g2 = 4'd2; cfg_w2 = 5'd16; cfg_lat = 2'd0;
        load_model();
        run_to_done(6);
        chk("R2 retrains with extra start", rtr_cnt, 2);
        chk("R2 capability writes", cap_wr_cnt, 1);
        chk("R8 err cleared on start", {31'd0, err}, 32'd0);
        chk("R7 width 16", {27'd0, cur_width}, 32'd16);
        repeat (4) @(negedge clk);
        chk("R9 idle no request", {31'd0, bus_req}, 32'd0);
        chk("R2 no further retrain", rtr_cnt, 2);
        chk("R10 handshake", hs_bad, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule